// File: doc/BRIEF.md
# IOMMU Page Translation Lookup

This block turns the I/O virtual address of a device access into a physical page address. It uses a table of 64-bit translation entries. The address's page number picks one entry. The lookup returns four things: the page-aligned I/O address, the physical page taken from the entry, a mask that covers the page-offset bits, and a two-bit access right. A grant output says whether that right covers the direction of the access, read or write.

The page size and the number of entries are fixed at elaboration. The table sits in flip-flops and has one write port, which a separate update engine drives. Reset empties the table, so every page faults until software programs it. A page number at or past the end of the table gives a no-access result with an all-ones mask. It does not raise an error.

Top module: `iova_xlate`

## Requirements
- R1: The page number is `req_addr >> PAGE_SHIFT`. It selects table entry number page. The lookup hits only when page < N_ENTRIES.
- R2: Bits [1:0] of an entry give the access right on `rsp_perm`: 0 = none (fault), 1 = read only, 2 = write only, 3 = read and write.
- R3: On a hit, `rsp_iova` equals `req_addr` with its low PAGE_SHIFT bits cleared.
- R4: On a hit, `rsp_phys` equals the entry with its low PAGE_SHIFT bits cleared, so the access bits never appear in it.
- R5: On a hit, `rsp_mask` equals 2^PAGE_SHIFT - 1, zero-extended to the entry width.
- R6: On a miss, `rsp_iova` and `rsp_phys` are zero, `rsp_perm` is 0, `rsp_grant` is 0 and `rsp_mask` is all ones.
- R7: Reset sets every entry to zero. Until an entry is written, a lookup of that page returns right 0, physical page 0 and no grant.
- R8: A request in cycle t gives `rsp_valid` high in cycle t+1. `rsp_valid` is low in any cycle that follows a cycle with no request.
- R9: `rsp_grant` is high for a read when right bit 0 is set, and for a write when right bit 1 is set. A miss never gives a grant.
- R10: A table write in cycle t is seen by a lookup issued in cycle t+1. A lookup issued in the same cycle t still sees the old entry.
- R11: The translation window spans N_ENTRIES * 2^PAGE_SHIFT bytes from address 0. The last byte of the window hits, and the first byte past it misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the table and the response |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | I/O virtual address to translate |
| req_is_write | input | 1 | 1 = write access, 0 = read access |
| upd_en | input | 1 | Table write strobe |
| upd_index | input | TBL_W | Entry number to write |
| upd_data | input | ENTRY_W | New entry value |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_iova | output | ADDR_W | Page-aligned I/O address |
| rsp_phys | output | ENTRY_W | Translated physical page address |
| rsp_mask | output | ENTRY_W | Page-offset mask (all ones on a miss) |
| rsp_perm | output | 2 | Access right from the entry |
| rsp_grant | output | 1 | Access right covers the requested direction |

## Verification
A wrong table entry shows at the ports on the very next lookup of that page, as a wrong physical page, access right or grant. It stays hidden until that page is looked up, so the bench sweeps every page number in both directions. A wrong in-range decision shows as a swapped mask: all ones where the page mask belongs, or the reverse. It appears one cycle after the request for a page at the window edge. Write-port timing faults show up in the back-to-back write and lookup case. There a stale or early value shows up at once on the response that follows.

// File: rtl/iox_pkg.sv
package iox_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2,
    ACC_RW   = 2'd3
  } acc_e;

  function automatic acc_e acc_decode(input logic [1:0] low_bits);
    return acc_e'(low_bits);
  endfunction

  function automatic logic acc_allows(input acc_e right, input logic is_wr);
    logic [1:0] r;
    r = right;
    return is_wr ? r[1] : r[0];
  endfunction

endpackage

// File: rtl/iox_table.sv
module iox_table #(
  parameter int ENTRY_W   = 64,
  parameter int N_ENTRIES = 12,
  parameter int TBL_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [TBL_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [TBL_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);

  logic [ENTRY_W-1:0] ent [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [ENTRY_W-1:0] q;
    logic               sel;
    assign sel = wr_en && (wr_idx == TBL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (sel) q <= wr_data;
    end
    assign ent[g] = q;

    // R10: a write lands in the addressed entry on the next edge
    p_entry_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == TBL_W'(g)) |=> (q == $past(wr_data)));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (rd_idx == TBL_W'(i)) rd_data = ent[i];
    end
  end

endmodule

// File: rtl/iox_lookup.sv
module iox_lookup
  import iox_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int ENTRY_W    = 64,
  parameter int PAGE_SHIFT = 4,
  parameter int N_ENTRIES  = 12,
  parameter int TBL_W      = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_wr,
  input  logic [ENTRY_W-1:0] entry,
  output logic [TBL_W-1:0]   tbl_idx,
  output logic               hit,
  output logic [ADDR_W-1:0]  iova,
  output logic [ENTRY_W-1:0] phys,
  output logic [ENTRY_W-1:0] mask,
  output logic [1:0]         perm,
  output logic               grant
);

  localparam int PIDX_W = ADDR_W - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0]  OFF_A = {{PIDX_W{1'b0}}, {PAGE_SHIFT{1'b1}}};
  localparam logic [ENTRY_W-1:0] OFF_E = {{(ENTRY_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
  localparam logic [PIDX_W:0]    LIMIT = (PIDX_W+1)'(N_ENTRIES);

  function automatic logic [PIDX_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_SHIFT];
  endfunction

  function automatic logic [ENTRY_W-1:0] strip_offset(input logic [ENTRY_W-1:0] e);
    return e & ~OFF_E;
  endfunction

  logic [PIDX_W-1:0] page;
  acc_e              right;

  assign page    = page_of(addr);
  assign hit     = ({1'b0, page} < LIMIT);
  assign tbl_idx = TBL_W'(page);

  always_comb begin
    if (hit) begin
      iova  = addr & ~OFF_A;
      phys  = strip_offset(entry);
      mask  = OFF_E;
      right = acc_decode(entry[1:0]);
    end else begin
      iova  = '0;
      phys  = '0;
      mask  = '1;
      right = ACC_NONE;
    end
  end

  assign perm  = right;
  assign grant = hit && acc_allows(right, is_wr);

endmodule

// File: rtl/iox_rsp_reg.sv
module iox_rsp_reg #(
  parameter int ADDR_W  = 16,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_hit,
  input  logic               in_wr,
  input  logic [ADDR_W-1:0]  in_iova,
  input  logic [ENTRY_W-1:0] in_phys,
  input  logic [ENTRY_W-1:0] in_mask,
  input  logic [1:0]         in_perm,
  input  logic               in_grant,
  output logic               out_valid,
  output logic               out_hit,
  output logic               out_wr,
  output logic [ADDR_W-1:0]  out_iova,
  output logic [ENTRY_W-1:0] out_phys,
  output logic [ENTRY_W-1:0] out_mask,
  output logic [1:0]         out_perm,
  output logic               out_grant
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_wr    <= 1'b0;
      out_iova  <= '0;
      out_phys  <= '0;
      out_mask  <= '0;
      out_perm  <= '0;
      out_grant <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit   <= in_hit;
        out_wr    <= in_wr;
        out_iova  <= in_iova;
        out_phys  <= in_phys;
        out_mask  <= in_mask;
        out_perm  <= in_perm;
        out_grant <= in_grant;
      end
    end
  end

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate #(
  parameter int ADDR_W     = 16,
  parameter int ENTRY_W    = 64,
  parameter int PAGE_SHIFT = 4,
  parameter int N_ENTRIES  = 12,
  parameter int TBL_W      = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_is_write,
  input  logic               upd_en,
  input  logic [TBL_W-1:0]   upd_index,
  input  logic [ENTRY_W-1:0] upd_data,
  output logic               rsp_valid,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ENTRY_W-1:0] rsp_phys,
  output logic [ENTRY_W-1:0] rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_grant
);

  localparam longint unsigned WINDOW = longint'(N_ENTRIES) << PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] OFF_A = ADDR_W'((1 << PAGE_SHIFT) - 1);

  logic [TBL_W-1:0]   lk_idx;
  logic [ENTRY_W-1:0] lk_entry;
  logic               lk_hit;
  logic [ADDR_W-1:0]  lk_iova;
  logic [ENTRY_W-1:0] lk_phys;
  logic [ENTRY_W-1:0] lk_mask;
  logic [1:0]         lk_perm;
  logic               lk_grant;
  logic               rsp_hit;
  logic               rsp_dir;

  iox_table #(
    .ENTRY_W(ENTRY_W), .N_ENTRIES(N_ENTRIES), .TBL_W(TBL_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(upd_en), .wr_idx(upd_index), .wr_data(upd_data),
    .rd_idx(lk_idx), .rd_data(lk_entry)
  );

  iox_lookup #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .PAGE_SHIFT(PAGE_SHIFT),
    .N_ENTRIES(N_ENTRIES), .TBL_W(TBL_W)
  ) u_lookup (
    .addr(req_addr), .is_wr(req_is_write), .entry(lk_entry),
    .tbl_idx(lk_idx), .hit(lk_hit), .iova(lk_iova), .phys(lk_phys),
    .mask(lk_mask), .perm(lk_perm), .grant(lk_grant)
  );

  iox_rsp_reg #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)
  ) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_hit(lk_hit), .in_wr(req_is_write),
    .in_iova(lk_iova), .in_phys(lk_phys), .in_mask(lk_mask),
    .in_perm(lk_perm), .in_grant(lk_grant),
    .out_valid(rsp_valid), .out_hit(rsp_hit), .out_wr(rsp_dir),
    .out_iova(rsp_iova), .out_phys(rsp_phys), .out_mask(rsp_mask),
    .out_perm(rsp_perm), .out_grant(rsp_grant)
  );

  // R8: response one cycle after each request, none otherwise
  p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R6: a miss yields the no-access result
  p_miss_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_mask == '1 && rsp_perm == 2'd0 &&
                                 rsp_phys == '0 && rsp_iova == '0 && !rsp_grant));

  // R4: the physical page never carries offset or access bits
  p_phys_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_phys & rsp_mask) == '0));

  // R3: aligned I/O address follows the request address
  p_iova_from_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_iova == ($past(req_addr) & ~OFF_A)));

  // R9: a grant only when the right covers the direction
  p_grant_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> (rsp_hit && (rsp_dir ? rsp_perm[1] : rsp_perm[0])));

  // R11: hits only inside the window
  p_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (longint'($past(req_addr)) < WINDOW));

endmodule

// File: tb/test_iova_xlate.sv
module test_iova_xlate;

  localparam int AW = 16;
  localparam int EW = 64;
  localparam int PS = 4;
  localparam int NE = 12;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_is_write = 1'b0;
  logic          upd_en = 1'b0;
  logic [TW-1:0] upd_index = '0;
  logic [EW-1:0] upd_data = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_iova;
  logic [EW-1:0] rsp_phys;
  logic [EW-1:0] rsp_mask;
  logic [1:0]    rsp_perm;
  logic          rsp_grant;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [EW-1:0] shadow [NE];

  always #2.5 clk = ~clk;

  iova_xlate #(.ADDR_W(AW), .ENTRY_W(EW), .PAGE_SHIFT(PS), .N_ENTRIES(NE)) i_iova_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_write(req_is_write), .upd_en(upd_en), .upd_index(upd_index),
    .upd_data(upd_data), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
    .rsp_phys(rsp_phys), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
    .rsp_grant(rsp_grant)
  );

  task automatic chk(input bit ok, input string req, input logic [EW-1:0] act,
                     input logic [EW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] pattern(input int i);
    return 64'h0F1E_2D3C_4B5A_6000 ^ (64'(i) << 24) ^ 64'((i * 7) & 15);
  endfunction

  task automatic write_entry(input int idx, input logic [EW-1:0] d);
    @(negedge clk);
    upd_en = 1'b1; upd_index = TW'(idx); upd_data = d;
    @(negedge clk);
    upd_en = 1'b0;
    shadow[idx] = d;
  endtask

  // Issue a lookup and compare the response one cycle later.
  task automatic look(input logic [AW-1:0] a, input bit wr, input logic [EW-1:0] ent_exp);
    longint unsigned page;
    logic [EW-1:0] e_phys, e_mask;
    logic [AW-1:0] e_iova;
    int e_perm;
    bit e_grant;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    page = longint'(a) / (1 << PS);
    if (page < NE) begin
      e_iova  = AW'((longint'(a) / (1 << PS)) * (1 << PS));
      e_phys  = (ent_exp >> PS) << PS;
      e_mask  = EW'((1 << PS) - 1);
      e_perm  = int'(ent_exp % 4);
      e_grant = wr ? (e_perm >= 2) : (e_perm % 2 == 1);
    end else begin
      e_iova = '0; e_phys = '0; e_mask = {EW{1'b1}}; e_perm = 0; e_grant = 1'b0;
    end
    chk(rsp_valid == 1'b1, "R8 valid", 64'(rsp_valid), 64'd1);
    chk(rsp_iova == e_iova, "R3/R6 iova", 64'(rsp_iova), 64'(e_iova));
    chk(rsp_phys == e_phys, "R4/R6 phys", rsp_phys, e_phys);
    chk(rsp_mask == e_mask, "R5/R6 mask", rsp_mask, e_mask);
    chk(int'(rsp_perm) == e_perm, "R2 perm", 64'(rsp_perm), 64'(e_perm));
    chk(rsp_grant == e_grant, "R9 grant", 64'(rsp_grant), 64'(e_grant));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state of the response and of every entry
    chk(rsp_valid == 1'b0, "R7 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    for (int p = 0; p < NE; p++) begin
      look(AW'(p * 16 + 5), 1'b0, 64'd0);   // R7: cleared entries fault
      look(AW'(p * 16 + 9), 1'b1, 64'd0);
    end
    // R8: no request, no response
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 idle", 64'(rsp_valid), 64'd0);
    // Program every entry (R1, R2 cover all four access codes)
    for (int i = 0; i < NE; i++) write_entry(i, pattern(i));
    // R1..R6, R9: sweep every page number including beyond the table
    for (int p = 0; p < 16; p++) begin
      for (int w = 0; w < 2; w++) begin
        logic [AW-1:0] a;
        a = AW'(p * 16 + ((p * 3 + w * 5) % 16));
        look(a, w[0], (p < NE) ? shadow[p] : 64'd0);
      end
    end
    // R6: addresses far past the window
    look(16'hFFFF, 1'b0, 64'd0);
    look(16'h8000, 1'b1, 64'd0);
    // R11: window edges
    look(AW'(NE * 16 - 1), 1'b1, shadow[NE-1]);
    look(AW'(NE * 16), 1'b1, 64'd0);
    // R10: same-cycle lookup sees the old entry, the next one the new entry
    @(negedge clk);
    upd_en = 1'b1; upd_index = TW'(5); upd_data = 64'hDEAD_BEEF_0000_0073;
    req_valid = 1'b1; req_addr = AW'(5 * 16 + 2); req_is_write = 1'b0;
    @(negedge clk);
    upd_en = 1'b0;
    chk(rsp_phys == ((shadow[5] >> PS) << PS), "R10 same-cycle old value",
        rsp_phys, (shadow[5] >> PS) << PS);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_phys == 64'hDEAD_BEEF_0000_0070, "R10 next-cycle new value",
        rsp_phys, 64'hDEAD_BEEF_0000_0070);
    chk(rsp_perm == 2'd3, "R10 R2 new perm", 64'(rsp_perm), 64'd3);
    shadow[5] = 64'hDEAD_BEEF_0000_0073;
    // R2/R9: rewrite one entry through every access code
    for (int c = 0; c < 4; c++) begin
      write_entry(2, 64'h1234_5678_9ABC_DE00 | 64'(c));
      look(AW'(2 * 16 + 7), 1'b0, shadow[2]);
      look(AW'(2 * 16 + 7), 1'b1, shadow[2]);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule